// File: doc/BRIEF.md
# Packed SIMD Integer Divider

This unit divides 32-bit integer words. It can treat a word as one 32-bit lane, as two independent 16-bit lanes or as four independent 8-bit lanes. One request carries the dividend, the divisor, a lane-mode code, a signedness flag and a selector that picks the quotient or the remainder. The unit handles one divide at a time. It holds a busy signal toward the issuing pipeline while it iterates, then returns the packed result word together with a one-cycle done strobe.

The iterative core retires two quotient bits per lane in every cycle. The first pair is computed on the clock edge that accepts the request. A lane of width N therefore needs N/2 iterations, and the issuing pipeline stalls for N/2-1 cycles. Narrow lanes finish sooner than wide ones because the same sliced datapath serves every mode.

Signed divides run on lane magnitudes, and the signs are fixed on the way out. A zero divisor never traps. It yields a fixed, documented result in that lane only.

Top module: `packed_int_divider`

## Requirements
- R1: `req_mode` selects the lane layout: 2'b00 gives one 32-bit lane, 2'b01 gives two 16-bit lanes (bits 15:0 and 31:16), and 2'b10 or 2'b11 gives four 8-bit lanes (bits 8k+7:8k). Each lane's result depends only on that lane's operand bits, and no borrow or carry crosses a lane boundary.
- R2: With `req_signed`=0, every lane is divided as unsigned. `req_rem`=0 returns the quotient and `req_rem`=1 returns the remainder. `result` is valid during the cycle in which `done` is high.
- R3: With `req_signed`=1, lanes are two's complement. The quotient truncates toward zero and the remainder takes the sign of the dividend. The most negative value divided by -1 gives a quotient with the same bit pattern as the dividend and a remainder of 0.
- R4: A lane with a zero divisor returns all ones as its quotient and its own dividend as its remainder, for both signed and unsigned divides. No error is raised.
- R5: A request is accepted in a cycle where `req_valid` is high and `busy` is low. `busy` rises in the next cycle. `done` is high for exactly one cycle, the cycle after the last busy cycle, and `busy` is low in that cycle.
- R6: `busy` stays high for 15 cycles in 1x32 mode, 7 cycles in 2x16 mode and 3 cycles in 4x8 mode.
- R7: A request presented while `busy` is high is ignored. It changes neither the result nor the timing of the divide in flight.
- R8: A request presented in the `done` cycle is accepted, so divides can run back to back with no idle cycle between them.
- R9: While reset is asserted, and after it is released until a request is accepted, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_mode | input | 2 | Lane layout code (see R1) |
| req_signed | input | 1 | 1 = two's complement lanes, 0 = unsigned |
| req_rem | input | 1 | 1 = return remainder, 0 = return quotient |
| dividend | input | 32 | Packed dividend lanes |
| divisor | input | 32 | Packed divisor lanes |
| busy | output | 1 | Stall to the issuing pipeline while iterating |
| done | output | 1 | One-cycle strobe, result valid |
| result | output | 32 | Packed quotient or remainder lanes |

## Verification
A corrupted iteration counter or controller state shows up on the first divide. `busy` falls early or late compared with the 15/7/3-cycle stall, or `done` appears in the wrong cycle, and the cycle-accurate model flags the mismatch within at most 16 cycles of the request. A wrong bit in the partial remainder, quotient or sign-flag registers stays hidden until the `done` cycle. It then appears as a wrong lane value, so packed modes with values near lane boundaries, mixed signs and zero divisors are mixed with back-to-back and interrupted-request streams. Borrow leaking between lanes is visible only in packed modes where a lower lane's trial subtraction borrows, and the random operands include many such cases.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned SLICE_W = 8;
  localparam int unsigned N_SLICE = WORD_W / SLICE_W;

  typedef enum logic [1:0] {
    LANES_1X32 = 2'b00,
    LANES_2X16 = 2'b01,
    LANES_4X8  = 2'b10,
    LANES_ALT8 = 2'b11
  } lane_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_DONE = 2'b10
  } div_state_e;

  // number of byte slices forming one lane in a given layout
  function automatic int unsigned slices_per_lane(lane_mode_e m);
    case (m)
      LANES_1X32: return N_SLICE;
      LANES_2X16: return N_SLICE / 2;
      default:    return 1;
    endcase
  endfunction

  // index of the most significant slice of the lane holding slice i
  function automatic int unsigned lane_top(int unsigned i, lane_mode_e m);
    int unsigned s;
    s = slices_per_lane(m);
    return (i / s) * s + s - 1;
  endfunction

  // slices that begin a lane: borrow and carry chains are cut there
  function automatic logic [N_SLICE-1:0] start_mask(lane_mode_e m);
    logic [N_SLICE-1:0] msk;
    int unsigned s;
    s = slices_per_lane(m);
    for (int unsigned i = 0; i < N_SLICE; i++) msk[i] = ((i % s) == 0);
    return msk;
  endfunction

endpackage

// File: rtl/pdiv_segneg.sv
// Lane-segmented conditional two's complement negation.
module pdiv_segneg
  import pdiv_pkg::*;
(
  input  logic [WORD_W-1:0]  din,
  input  logic [N_SLICE-1:0] neg,
  input  logic [N_SLICE-1:0] lstart,
  output logic [WORD_W-1:0]  dout
);

  logic [N_SLICE-1:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
    logic               cin;
    logic [SLICE_W-1:0] src;
    assign cin = lstart[i] ? neg[i] : carry[i];
    assign src = neg[i] ? ~din[i*SLICE_W +: SLICE_W] : din[i*SLICE_W +: SLICE_W];
    if (i < N_SLICE - 1) begin : g_mid
      assign {carry[i+1], dout[i*SLICE_W +: SLICE_W]} =
        {1'b0, src} + {{SLICE_W{1'b0}}, cin};
    end else begin : g_top
      assign dout[i*SLICE_W +: SLICE_W] = src + {{(SLICE_W-1){1'b0}}, cin};
    end
  end

endmodule

// File: rtl/pdiv_step.sv
// One restoring radix-2 step applied to every lane at once.
module pdiv_step
  import pdiv_pkg::*;
(
  input  lane_mode_e        mode,
  input  logic [WORD_W-1:0] q_in,
  input  logic [WORD_W-1:0] r_in,
  input  logic [WORD_W-1:0] d_in,
  output logic [WORD_W-1:0] q_out,
  output logic [WORD_W-1:0] r_out
);

  logic [N_SLICE-1:0] smask;
  logic [N_SLICE-1:0] bo;
  logic [N_SLICE-1:0] ge;
  logic [WORD_W-1:0]  r_sh;
  logic [WORD_W-1:0]  q_sh;
  logic [WORD_W-1:0]  diff;

  always_comb begin
    logic brw;
    logic bin;
    smask = start_mask(mode);
    r_sh  = {r_in[WORD_W-2:0], 1'b0};
    q_sh  = {q_in[WORD_W-2:0], 1'b0};
    // each lane pulls the next dividend bit from its own top
    for (int unsigned i = 0; i < N_SLICE; i++) begin
      if (smask[i]) r_sh[i*SLICE_W] = q_in[lane_top(i, mode)*SLICE_W + SLICE_W - 1];
    end
    // trial subtraction, borrow cut at lane starts
    brw = 1'b0;
    for (int unsigned i = 0; i < N_SLICE; i++) begin
      bin = smask[i] ? 1'b0 : brw;
      {bo[i], diff[i*SLICE_W +: SLICE_W]} =
        {1'b0, r_sh[i*SLICE_W +: SLICE_W]} - {1'b0, d_in[i*SLICE_W +: SLICE_W]}
        - {{SLICE_W{1'b0}}, bin};
      brw = bo[i];
    end
    // lane outcome: the shifted-out bit or a clean subtract means it fits
    for (int unsigned i = 0; i < N_SLICE; i++) begin
      ge[i] = r_in[lane_top(i, mode)*SLICE_W + SLICE_W - 1] | ~bo[lane_top(i, mode)];
      r_out[i*SLICE_W +: SLICE_W] = ge[i] ? diff[i*SLICE_W +: SLICE_W]
                                          : r_sh[i*SLICE_W +: SLICE_W];
      if (smask[i]) q_sh[i*SLICE_W] = ge[i];
    end
    q_out = q_sh;
  end

endmodule

// File: rtl/pdiv_ctrl.sv
// Sequencer: accepts a request, counts iterations, raises busy and done.
module pdiv_ctrl
  import pdiv_pkg::*;
#(
  parameter int unsigned STEPS = 2
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       req_valid,
  input  lane_mode_e req_mode,
  output logic       accept,
  output logic       busy,
  output logic       done,
  output logic       step_en,
  output lane_mode_e mode_q
);

  localparam int unsigned MAX_ITER = WORD_W / STEPS;
  localparam int unsigned CNT_W    = $clog2(MAX_ITER) + 1;

  function automatic logic [CNT_W-1:0] iters_of(lane_mode_e m);
    return CNT_W'((slices_per_lane(m) * SLICE_W) / STEPS);
  endfunction

  div_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  lane_mode_e       mode_d;

  assign busy    = (st_q == ST_RUN);
  assign done    = (st_q == ST_DONE);
  assign accept  = req_valid & ~busy;
  assign step_en = accept | busy;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    case (st_q)
      ST_RUN: begin
        if (cnt_q == CNT_W'(1)) st_d = ST_DONE;
        else                    cnt_d = cnt_q - CNT_W'(1);
      end
      default: begin
        st_d = ST_IDLE;
        if (accept) begin
          mode_d = req_mode;
          cnt_d  = iters_of(req_mode) - CNT_W'(1);
          st_d   = (iters_of(req_mode) == CNT_W'(1)) ? ST_DONE : ST_RUN;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mode_q <= LANES_1X32;
    end else begin
      st_q <= st_d;
      if (step_en) cnt_q  <= cnt_d;
      if (accept)  mode_q <= mode_d;
    end
  end

  // checker: length of the current busy run
  logic [CNT_W-1:0] run_len;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   run_len <= '0;
    else if (busy) run_len <= run_len + CNT_W'(1);
    else           run_len <= '0;
  end

  p_accept_starts_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    accept |=> (busy || done));

  p_fall_with_done_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy) |-> done);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);

  p_stall_len_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy) |-> (run_len == iters_of(mode_q) - CNT_W'(1)));

endmodule

// File: rtl/packed_int_divider.sv
module packed_int_divider
  import pdiv_pkg::*;
#(
  parameter int unsigned STEPS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic              req_signed,
  input  logic              req_rem,
  input  logic [WORD_W-1:0] dividend,
  input  logic [WORD_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] result
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  lane_mode_e req_m;
  lane_mode_e mode_r;
  logic       accept;
  logic       step_en;
  assign req_m = lane_mode_e'(req_mode);

  pdiv_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .req_valid(req_valid),
    .req_mode (req_m),
    .accept   (accept),
    .busy     (busy),
    .done     (done),
    .step_en  (step_en),
    .mode_q   (mode_r)
  );

  // ---------------- entry stage: lane signs, zero divisors, magnitudes
  logic [N_SLICE-1:0] a_neg, b_neg, b_zero, slice_zero;
  logic [N_SLICE-1:0] qneg_d, rneg_d;
  logic [WORD_W-1:0]  a_mag, b_mag;

  always_comb begin
    for (int unsigned j = 0; j < N_SLICE; j++)
      slice_zero[j] = ~|divisor[j*SLICE_W +: SLICE_W];
    for (int unsigned i = 0; i < N_SLICE; i++) begin
      a_neg[i]  = req_signed & dividend[lane_top(i, req_m)*SLICE_W + SLICE_W - 1];
      b_neg[i]  = req_signed & divisor[lane_top(i, req_m)*SLICE_W + SLICE_W - 1];
      b_zero[i] = 1'b1;
      for (int unsigned j = 0; j < N_SLICE; j++)
        if (lane_top(j, req_m) == lane_top(i, req_m)) b_zero[i] = b_zero[i] & slice_zero[j];
    end
    qneg_d = (a_neg ^ b_neg) & ~b_zero;
    rneg_d = a_neg;
  end

  pdiv_segneg u_abs_a (.din(dividend), .neg(a_neg), .lstart(start_mask(req_m)), .dout(a_mag));
  pdiv_segneg u_abs_b (.din(divisor),  .neg(b_neg), .lstart(start_mask(req_m)), .dout(b_mag));

  // ---------------- iterative stage
  logic [WORD_W-1:0]  q_r, r_r, d_r;
  logic [N_SLICE-1:0] qneg_r, rneg_r;
  logic               op_r;

  logic [WORD_W-1:0] q_c [STEPS+1];
  logic [WORD_W-1:0] r_c [STEPS+1];
  logic [WORD_W-1:0] d_in;
  lane_mode_e        mode_in;

  assign q_c[0]  = accept ? a_mag : q_r;
  assign r_c[0]  = accept ? '0    : r_r;
  assign d_in    = accept ? b_mag : d_r;
  assign mode_in = accept ? req_m : mode_r;

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    pdiv_step u_step (
      .mode (mode_in),
      .q_in (q_c[s]),
      .r_in (r_c[s]),
      .d_in (d_in),
      .q_out(q_c[s+1]),
      .r_out(r_c[s+1])
    );
  end

  always_ff @(posedge clk) begin
    if (step_en) begin
      q_r <= q_c[STEPS];
      r_r <= r_c[STEPS];
    end
    if (accept) begin
      d_r    <= b_mag;
      qneg_r <= qneg_d;
      rneg_r <= rneg_d;
      op_r   <= req_rem;
    end
  end

  // ---------------- output stage: sign restore and selection
  logic [WORD_W-1:0] quo_fix, rem_fix;

  pdiv_segneg u_fix_q (.din(q_r), .neg(qneg_r), .lstart(start_mask(mode_r)), .dout(quo_fix));
  pdiv_segneg u_fix_r (.din(r_r), .neg(rneg_r), .lstart(start_mask(mode_r)), .dout(rem_fix));

  assign result = op_r ? rem_fix : quo_fix;

  // partial remainder stays below the divisor magnitude in every lane
  for (genvar k = 0; k < N_SLICE; k++) begin : g_chk8
    p_rem_bound8_r2: assert property (@(posedge clk) disable iff (!rst_ni)
      ((busy || done) && slices_per_lane(mode_r) == 1 && d_r[k*SLICE_W +: SLICE_W] != '0)
      |-> (r_r[k*SLICE_W +: SLICE_W] < d_r[k*SLICE_W +: SLICE_W]));
  end

  p_rem_bound32_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    ((busy || done) && mode_r == LANES_1X32 && d_r != '0) |-> (r_r < d_r));

endmodule

// File: tb/packed_int_divider_tb.sv
module packed_int_divider_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_mode;
  logic        req_signed;
  logic        req_rem;
  logic [31:0] dividend;
  logic [31:0] divisor;
  logic        busy;
  logic        done;
  logic [31:0] result;

  packed_int_divider u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_signed(req_signed), .req_rem(req_rem), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .result(result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int          n_checks = 0;
  int          n_errors = 0;
  int          m_left   = 0;   // cycles until the model's done cycle (0 = idle)
  logic [31:0] m_res;
  string       m_tag;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int stall_of(input logic [1:0] m);
    return (m == 2'b00) ? 15 : (m == 2'b01) ? 7 : 3;
  endfunction

  function automatic logic [31:0] ref_div(input logic [31:0] a, input logic [31:0] b,
                                          input logic [1:0] m, input logic s, input logic rm);
    int          w;
    longint      mask, ua, ub, sa, sb, q, r, v;
    logic [31:0] outw;
    w    = (m == 2'b00) ? 32 : (m == 2'b01) ? 16 : 8;
    mask = (longint'(1) <<< w) - 1;
    outw = '0;
    for (int k = 0; k < 32 / w; k++) begin
      ua = (longint'(a) >> (k * w)) & mask;
      ub = (longint'(b) >> (k * w)) & mask;
      if (ub == 0) begin
        q = mask;
        r = ua;
      end else if (s) begin
        sa = (ua >= (longint'(1) <<< (w - 1))) ? ua - (mask + 1) : ua;
        sb = (ub >= (longint'(1) <<< (w - 1))) ? ub - (mask + 1) : ub;
        q  = sa / sb;
        r  = sa % sb;
      end else begin
        q = ua / ub;
        r = ua % ub;
      end
      v    = (rm ? r : q) & mask;
      outw = outw | (32'(v) << (k * w));
    end
    return outw;
  endfunction

  // one clock cycle: drive, compare against the model, advance the model
  task automatic tick(input logic v, input logic [1:0] m, input logic s, input logic rm,
                      input logic [31:0] a, input logic [31:0] b, input string tag);
    bit exp_busy, exp_done;
    @(negedge clk);
    req_valid = v; req_mode = m; req_signed = s; req_rem = rm;
    dividend  = a; divisor  = b;
    exp_busy = (m_left >= 2);
    exp_done = (m_left == 1);
    chk(busy == exp_busy, "R6 busy", 32'(busy), 32'(exp_busy));
    chk(done == exp_done, "R5 done", 32'(done), 32'(exp_done));
    if (exp_done) chk(result == m_res, m_tag, result, m_res);
    if (v && !exp_busy) begin
      m_left = stall_of(m) + 1;
      m_res  = ref_div(a, b, m, s, rm);
      m_tag  = tag;
    end else if (m_left > 0) begin
      m_left--;
    end
  endtask

  task automatic run_op(input logic [1:0] m, input logic s, input logic rm,
                        input logic [31:0] a, input logic [31:0] b, input string tag,
                        input bit noisy);
    tick(1'b1, m, s, rm, a, b, tag);
    while (m_left > 1) begin
      if (noisy) tick(1'b1, 2'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom, tag);
      else       tick(1'b0, m, s, rm, a, b, tag);
    end
  endtask

  task automatic drain();
    while (m_left > 0) tick(1'b0, 2'b00, 1'b0, 1'b0, '0, '0, "idle");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'b00; req_signed = 1'b0;
    req_rem = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 busy in reset", 32'(busy), 32'd0);
    chk(done == 1'b0, "R9 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick(1'b0, 2'b00, 1'b0, 1'b0, '0, '0, "R9");

    // unsigned, all layouts, both selections
    run_op(2'b00, 1'b0, 1'b0, 32'd100, 32'd7, "R2 u32 quo", 1'b0);
    run_op(2'b00, 1'b0, 1'b1, 32'd100, 32'd7, "R2 u32 rem", 1'b0);
    run_op(2'b00, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd3, "R2 u32 max", 1'b0);
    run_op(2'b00, 1'b0, 1'b1, 32'h8765_4321, 32'hFFFF_FFFF, "R2 u32 big divisor", 1'b0);
    drain();
    run_op(2'b01, 1'b0, 1'b0, {16'd1000, 16'd65535}, {16'd33, 16'd255}, "R2 u16 quo", 1'b0);
    run_op(2'b01, 1'b0, 1'b1, {16'd1000, 16'd65535}, {16'd33, 16'd255}, "R2 u16 rem", 1'b0);
    run_op(2'b10, 1'b0, 1'b0, 32'hFF80_0A64, 32'h0F03_0207, "R1 u8 quo", 1'b0);
    run_op(2'b11, 1'b0, 1'b1, 32'hFF80_0A64, 32'h0F03_0207, "R1 mode11 rem", 1'b0);
    // lane isolation where lower lanes borrow
    run_op(2'b01, 1'b0, 1'b0, 32'h0001_0000, 32'h0000_0001, "R1 u16 isolation", 1'b0);
    run_op(2'b10, 1'b0, 1'b1, 32'h0100_0100, 32'h02FF_02FF, "R1 u8 isolation", 1'b0);
    drain();

    // signed
    run_op(2'b00, 1'b1, 1'b0, -32'sd100, 32'sd7, "R3 s32 neg/pos quo", 1'b0);
    run_op(2'b00, 1'b1, 1'b1, -32'sd100, 32'sd7, "R3 s32 neg/pos rem", 1'b0);
    run_op(2'b00, 1'b1, 1'b1, 32'sd100, -32'sd7, "R3 s32 pos/neg rem", 1'b0);
    run_op(2'b00, 1'b1, 1'b0, -32'sd100, -32'sd7, "R3 s32 neg/neg quo", 1'b0);
    run_op(2'b00, 1'b1, 1'b0, 32'h8000_0000, 32'hFFFF_FFFF, "R3 s32 overflow quo", 1'b0);
    run_op(2'b00, 1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R3 s32 overflow rem", 1'b0);
    run_op(2'b10, 1'b1, 1'b0, 32'h80F9_7F80, 32'hFF02_FD7F, "R3 s8 quo", 1'b0);
    run_op(2'b01, 1'b1, 1'b1, 32'h8001_FF9C, 32'h0003_0007, "R3 s16 rem", 1'b0);
    drain();

    // zero divisors
    run_op(2'b00, 1'b0, 1'b0, 32'h1234_5678, 32'd0, "R4 u32 zero quo", 1'b0);
    run_op(2'b00, 1'b1, 1'b1, 32'hF234_5678, 32'd0, "R4 s32 zero rem", 1'b0);
    run_op(2'b00, 1'b1, 1'b0, 32'hF234_5678, 32'd0, "R4 s32 zero quo", 1'b0);
    run_op(2'b01, 1'b1, 1'b0, 32'h8123_0042, 32'h0000_0005, "R4 s16 zero lane", 1'b0);
    run_op(2'b10, 1'b1, 1'b1, 32'h85FF_1203, 32'h0003_0000, "R4 s8 zero rem", 1'b0);
    drain();

    // requests while busy must be ignored
    run_op(2'b00, 1'b0, 1'b0, 32'd123456789, 32'd1000, "R7 ignored u32", 1'b1);
    run_op(2'b01, 1'b1, 1'b1, 32'h9000_7000, 32'h0013_FFF9, "R7 ignored s16", 1'b1);
    run_op(2'b10, 1'b0, 1'b0, 32'hC8A0_5A10, 32'h0907_0503, "R7 ignored u8", 1'b1);
    drain();
    // back to back across layouts, each taken in the previous done cycle
    run_op(2'b10, 1'b0, 1'b0, 32'h6432_1E0F, 32'h0A05_0302, "R8 b2b 8", 1'b0);
    run_op(2'b00, 1'b0, 1'b1, 32'd99999, 32'd97, "R8 b2b 32", 1'b0);
    run_op(2'b01, 1'b1, 1'b0, 32'hFF00_0100, 32'h0010_FFF0, "R8 b2b 16", 1'b0);
    run_op(2'b10, 1'b1, 1'b1, 32'h7F81_0280, 32'h03FD_FFFF, "R8 b2b 8 signed", 1'b0);
    drain();

    // random mixture
    for (int n = 0; n < 400; n++) begin
      logic [1:0]  m;
      logic        s, rm;
      logic [31:0] a, b;
      int          sel;
      m   = 2'($urandom_range(0, 3));
      s   = 1'($urandom);
      rm  = 1'($urandom);
      a   = $urandom;
      b   = $urandom;
      sel = $urandom_range(0, 7);
      if (sel == 0)      b = b & 32'hFF00_FF00;
      else if (sel == 1) b = b & 32'h0303_0303;
      else if (sel == 2) b = '0;
      if (s) run_op(m, s, rm, a, b, "R3 random signed", n % 5 == 0);
      else   run_op(m, s, rm, a, b, "R2 random unsigned", n % 5 == 0);
      if (n % 7 == 0) drain();
    end
    drain();
    for (int i = 0; i < 3; i++) tick(1'b0, 2'b00, 1'b0, 1'b0, '0, '0, "idle");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule